// File: doc/BRIEF.md
# Instrument Status Reporting Register Block

This block holds the status reporting state of a programmable instrument. Completion and error conditions arrive as single-cycle pulses and are latched into a sticky standard event register. An event enable mask selects which latched bits combine into an event summary. That summary is merged with three summary inputs from elsewhere in the instrument: the channel summary, the questionable summary and the output-queue-not-empty flag. Together they form a status byte.

A service request enable mask reduces the status byte to a master summary. A rising edge of that summary latches a request-service bit, which drives the service request output. The status byte can be seen two ways. The query view shows the master summary in bit 6 and is free of side effects. The serial poll view shows the request-service bit in bit 6, and its read strobe clears that bit.

Reading the event register clears it. A clear-status strobe clears both the event register and the request-service bit. Command parsing, the output queue and the channel and questionable register trees are outside this block.

Top module: `stat_report_top`

## Requirements
- R1: After reset, the event register, both status byte views and the service request output are all zero.
- R2: An event pulse on bit 0 (operation complete), 2 (query error), 3 (device-dependent error), 4 (execution error) or 5 (command error) sets that event register bit at the next clock edge. The bit stays set until it is cleared.
- R3: Event pulses on bits 1, 6 and 7 have no effect, and those event register bits always read zero.
- R4: A read strobe on the event register clears all of its bits at the next clock edge.
- R5: An event pulse arriving in the same cycle as a read strobe or a clear-status strobe leaves its bit set after that edge.
- R6: Status byte bit 5 is the OR of the bitwise AND of the event register and the event enable register. It follows both registers in the same cycle.
- R7: In both status byte views, bit 2 equals the channel summary input, bit 3 the questionable input and bit 4 the message-available input, in the same cycle. Bits 0, 1 and 7 read zero.
- R8: In the query view, bit 6 is high exactly when some status byte bit in positions 0 to 5 or 7 is high and is also set in the service request enable register. Reading this view clears nothing.
- R9: When the master summary rises, the request-service bit is set at the next edge. While it is set, the service request output is high and bit 6 of the poll view is high.
- R10: A serial poll read strobe clears the request-service bit at the next edge and leaves every other status byte bit unchanged. A master summary that stays high does not set it again.
- R11: A clear-status strobe clears the event register and the request-service bit at the next edge.
- R12: Bit 6 of the service request enable register has no effect on the master summary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_pulse_i | input | 8 | Single-cycle event pulses, one per event register bit |
| evt_rd_i | input | 1 | Event register read strobe, clears the register |
| ese_wr_i | input | 1 | Event enable register write strobe |
| ese_wdata_i | input | 8 | Event enable write data |
| sre_wr_i | input | 1 | Service request enable write strobe |
| sre_wdata_i | input | 8 | Service request enable write data |
| cls_i | input | 1 | Clear-status strobe |
| poll_rd_i | input | 1 | Serial poll read strobe |
| csum_i | input | 1 | Channel summary |
| ques_i | input | 1 | Questionable summary |
| mav_i | input | 1 | Output queue holds data |
| evt_reg_o | output | 8 | Event register value |
| stb_query_o | output | 8 | Status byte, bit 6 = master summary |
| stb_poll_o | output | 8 | Status byte, bit 6 = request-service |
| srq_o | output | 1 | Service request |

## Verification
Event pulses, strobes and mask writes are registered, so their results appear one edge after the cycle in which they are driven. The bench drives inputs 1 ns after a rising edge and checks registered results after the following edge. Bits 2 to 6 of the query view depend combinationally on the summary inputs and on registered state, so they are checked in the same cycle as the input change. The request-service bit takes one edge after the master summary rises. The sweep over every service request mask and every summary pattern checks the query view alone, so the changing request-service state does not affect its expected values.

// File: rtl/stat_pkg.sv
package stat_pkg;
  localparam int unsigned SB_W = 8;

  localparam int unsigned EV_OPC = 0;
  localparam int unsigned EV_QYE = 2;
  localparam int unsigned EV_DDE = 3;
  localparam int unsigned EV_EXE = 4;
  localparam int unsigned EV_CME = 5;

  localparam int unsigned SB_CSUM = 2;
  localparam int unsigned SB_QUES = 3;
  localparam int unsigned SB_MAV  = 4;
  localparam int unsigned SB_ESB  = 5;
  localparam int unsigned SB_RQS  = 6;

  localparam logic [SB_W-1:0] EV_VALID =
    SB_W'((1 << EV_OPC) | (1 << EV_QYE) | (1 << EV_DDE) | (1 << EV_EXE) | (1 << EV_CME));
endpackage

// File: rtl/stat_evt_reg.sv
module stat_evt_reg
  import stat_pkg::*;
#(
  parameter int unsigned W = SB_W,
  parameter logic [W-1:0] VALID = EV_VALID
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pulse_i,
  input  logic         clr_i,
  input  logic         ena_wr_i,
  input  logic [W-1:0] ena_wdata_i,
  output logic [W-1:0] evt_o,
  output logic         sum_o
);
  logic [W-1:0] ena_q;

  for (genvar b = 0; b < W; b++) begin : g_bit
    if (VALID[b]) begin : g_live
      logic bit_q;
      // set beats clear so a same-cycle event survives
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)         bit_q <= 1'b0;
        else if (pulse_i[b]) bit_q <= 1'b1;
        else if (clr_i)      bit_q <= 1'b0;
      end
      assign evt_o[b] = bit_q;
    end else begin : g_dead
      assign evt_o[b] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ena_q <= '0;
    else if (ena_wr_i) ena_q <= ena_wdata_i;
  end

  assign sum_o = |(evt_o & ena_q);

  AST_EVT_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o & ~VALID) == '0) else $error("reserved event bit set"); // R3

  AST_EVT_PULSE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pulse_i & VALID) != '0) |=> ((evt_o & $past(pulse_i & VALID)) == $past(pulse_i & VALID)))
    else $error("event pulse lost"); // R5

  AST_EVT_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && ((pulse_i & VALID) == '0)) |=> (evt_o == '0))
    else $error("event register not cleared"); // R4

  AST_EVT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i) |=> ((evt_o & $past(evt_o)) == $past(evt_o)))
    else $error("sticky bit dropped"); // R2
endmodule

// File: rtl/stat_svc_req.sv
module stat_svc_req
  import stat_pkg::*;
#(
  parameter int unsigned W = SB_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         esb_i,
  input  logic         csum_i,
  input  logic         ques_i,
  input  logic         mav_i,
  input  logic         sre_wr_i,
  input  logic [W-1:0] sre_wdata_i,
  input  logic         poll_rd_i,
  input  logic         cls_i,
  output logic [W-1:0] stb_query_o,
  output logic [W-1:0] stb_poll_o,
  output logic         srq_o
);
  localparam logic [W-1:0] RQS_BIT = W'(1 << SB_RQS);

  logic [W-1:0] sre_q;
  logic [W-1:0] stb_base;
  logic         mss, mss_q, rqs_q, mss_rise;

  always_comb begin
    stb_base          = '0;
    stb_base[SB_CSUM] = csum_i;
    stb_base[SB_QUES] = ques_i;
    stb_base[SB_MAV]  = mav_i;
    stb_base[SB_ESB]  = esb_i;
  end

  assign mss      = |(stb_base & sre_q & ~RQS_BIT);
  assign mss_rise = mss & ~mss_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sre_q <= '0;
    else if (sre_wr_i) sre_q <= sre_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mss_q <= 1'b0;
      rqs_q <= 1'b0;
    end else begin
      mss_q <= mss;
      if (mss_rise)                rqs_q <= 1'b1;
      else if (poll_rd_i || cls_i) rqs_q <= 1'b0;
    end
  end

  assign stb_query_o = stb_base | (mss   ? RQS_BIT : '0);
  assign stb_poll_o  = stb_base | (rqs_q ? RQS_BIT : '0);
  assign srq_o       = rqs_q;

  AST_RQS_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mss && !mss_q) |=> srq_o) else $error("rqs not set"); // R9

  AST_POLL_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((poll_rd_i || cls_i) && !(mss && !mss_q)) |=> !srq_o)
    else $error("rqs not cleared"); // R10

  AST_RQS_NEEDS_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(srq_o) |-> $past(stb_query_o[SB_RQS]))
    else $error("rqs set without master summary"); // R9

  AST_VIEWS_AGREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_query_o & ~RQS_BIT) == (stb_poll_o & ~RQS_BIT))
    else $error("views differ outside bit 6"); // R7
endmodule

// File: rtl/stat_report_top.sv
module stat_report_top
  import stat_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [SB_W-1:0] evt_pulse_i,
  input  logic            evt_rd_i,
  input  logic            ese_wr_i,
  input  logic [SB_W-1:0] ese_wdata_i,
  input  logic            sre_wr_i,
  input  logic [SB_W-1:0] sre_wdata_i,
  input  logic            cls_i,
  input  logic            poll_rd_i,
  input  logic            csum_i,
  input  logic            ques_i,
  input  logic            mav_i,
  output logic [SB_W-1:0] evt_reg_o,
  output logic [SB_W-1:0] stb_query_o,
  output logic [SB_W-1:0] stb_poll_o,
  output logic            srq_o
);
  logic esb;

  stat_evt_reg #(.W(SB_W), .VALID(EV_VALID)) u_evt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pulse_i    (evt_pulse_i),
    .clr_i      (evt_rd_i | cls_i),
    .ena_wr_i   (ese_wr_i),
    .ena_wdata_i(ese_wdata_i),
    .evt_o      (evt_reg_o),
    .sum_o      (esb)
  );

  stat_svc_req #(.W(SB_W)) u_svc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .esb_i      (esb),
    .csum_i     (csum_i),
    .ques_i     (ques_i),
    .mav_i      (mav_i),
    .sre_wr_i   (sre_wr_i),
    .sre_wdata_i(sre_wdata_i),
    .poll_rd_i  (poll_rd_i),
    .cls_i      (cls_i),
    .stb_query_o(stb_query_o),
    .stb_poll_o (stb_poll_o),
    .srq_o      (srq_o)
  );

  AST_CLS_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cls_i && evt_pulse_i == '0 && !stb_query_o[SB_RQS]) |=> (evt_reg_o == '0 && !srq_o))
    else $error("clear status incomplete"); // R11
endmodule

// File: tb/stat_report_top_tb_top.sv
module stat_report_top_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] evt_pulse_i = '0;
  logic       evt_rd_i = 1'b0, ese_wr_i = 1'b0, sre_wr_i = 1'b0;
  logic [7:0] ese_wdata_i = '0, sre_wdata_i = '0;
  logic       cls_i = 1'b0, poll_rd_i = 1'b0;
  logic       csum_i = 1'b0, ques_i = 1'b0, mav_i = 1'b0;
  logic [7:0] evt_reg_o, stb_query_o, stb_poll_o;
  logic       srq_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  stat_report_top dut_i (.*);

  task automatic step();
    @(posedge clk_i); #1;
  endtask

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic clear_all();
    cls_i = 1'b1; step(); cls_i = 1'b0;
  endtask

  task automatic wr_sre(logic [7:0] v);
    sre_wdata_i = v; sre_wr_i = 1'b1; step(); sre_wr_i = 1'b0;
  endtask

  task automatic wr_ese(logic [7:0] v);
    ese_wdata_i = v; ese_wr_i = 1'b1; step(); ese_wr_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] exp;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    step();
    // R1 reset state
    check("R1 evt", evt_reg_o, 8'h00);
    check("R1 query", stb_query_o, 8'h00);
    check("R1 poll", stb_poll_o, 8'h00);
    check("R1 srq", {7'd0, srq_o}, 8'h00);

    // R2 R3 R4: every pulse pattern latched then read-cleared
    for (int p = 0; p < 256; p++) begin
      evt_pulse_i = 8'(p); step(); evt_pulse_i = '0;
      step();
      check("R2_R3 latch", evt_reg_o, 8'(p) & 8'h3D);
      evt_rd_i = 1'b1; step(); evt_rd_i = 1'b0;
      check("R4 rd clear", evt_reg_o, 8'h00);
    end

    // R5 pulse during read-clear survives
    evt_pulse_i = 8'h20; step(); evt_pulse_i = '0;
    evt_pulse_i = 8'h10; evt_rd_i = 1'b1; step();
    evt_pulse_i = '0; evt_rd_i = 1'b0;
    check("R5 rd+pulse", evt_reg_o, 8'h10);
    evt_pulse_i = 8'h01; cls_i = 1'b1; step();
    evt_pulse_i = '0; cls_i = 1'b0;
    check("R5 cls+pulse", evt_reg_o, 8'h01);
    clear_all();

    // R6 event summary
    evt_pulse_i = 8'h08; step(); evt_pulse_i = '0;
    wr_ese(8'h37);
    check("R6 masked off", stb_query_o, 8'h00);
    wr_ese(8'h08);
    check("R6 enabled", stb_query_o, 8'h20);
    evt_rd_i = 1'b1; step(); evt_rd_i = 1'b0;
    check("R6 after read", stb_query_o, 8'h00);

    // R7 R8 R12: sweep ESB x all sre masks x summary inputs (query view)
    for (int e = 0; e < 2; e++) begin
      clear_all();
      evt_pulse_i = 8'h20; step(); evt_pulse_i = '0;
      wr_ese(e ? 8'h20 : 8'h00);
      for (int m = 0; m < 256; m++) begin
        wr_sre(8'(m));
        for (int s = 0; s < 8; s++) begin
          {mav_i, ques_i, csum_i} = 3'(s);
          #1;
          exp = 8'(s << 2) | (e ? 8'h20 : 8'h00);
          if ((exp & 8'(m) & 8'hBF) != 0) exp |= 8'h40;
          check("R7_R8_R12 query", stb_query_o, exp);
          check("R7 poll low bits", stb_poll_o & 8'hBF, exp & 8'hBF);
        end
      end
    end
    {mav_i, ques_i, csum_i} = 3'b000;
    wr_ese(8'h00);
    clear_all();
    step();

    // R9 request-service on rising master summary
    wr_sre(8'h10);
    clear_all();
    check("R9 idle", {7'd0, srq_o}, 8'h00);
    mav_i = 1'b1; #1;
    check("R8 query immediate", stb_query_o, 8'h50);
    check("R9 not yet", stb_poll_o, 8'h10);
    step();
    check("R9 srq set", {7'd0, srq_o}, 8'h01);
    check("R9 poll view", stb_poll_o, 8'h50);
    step();
    check("R8 query no clear", stb_poll_o, 8'h50);

    // R10 serial poll clears rqs only
    poll_rd_i = 1'b1; step(); poll_rd_i = 1'b0;
    check("R10 poll cleared", stb_poll_o, 8'h10);
    check("R10 srq low", {7'd0, srq_o}, 8'h00);
    check("R10 query kept", stb_query_o, 8'h50);
    step(); step();
    check("R10 no re-set", {7'd0, srq_o}, 8'h00);
    mav_i = 1'b0; step(); mav_i = 1'b1; step();
    check("R9 new rise", {7'd0, srq_o}, 8'h01);

    // R11 clear-status
    evt_pulse_i = 8'h04; step(); evt_pulse_i = '0;
    check("R11 pre", evt_reg_o, 8'h04);
    clear_all();
    check("R11 evt", evt_reg_o, 8'h00);
    check("R11 srq", {7'd0, srq_o}, 8'h00);
    check("R11 mav kept", stb_poll_o, 8'h10);

    // R12 bit-6-only mask never requests service
    mav_i = 1'b0; wr_sre(8'h40);
    {mav_i, ques_i, csum_i} = 3'b111; step();
    check("R12 query", stb_query_o, 8'h1C);
    check("R12 srq", {7'd0, srq_o}, 8'h00);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule